// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the external bus cycles of a processor whose low address bits and data share one set of 16 lines in time. A client presents one transfer at a time on a simple valid/ready request port. The request carries the direction, a memory or I/O space flag, a 20-bit address, the write data, a two-bit segment class, a word/byte size and the current interrupt-enable flag. The block then steps the shared lines, the four upper address/status lines and the bus strobes through a fixed sequence of clocks.

Each cycle has a base length of four clocks: T1, T2, T3 and T4. T1 puts the address on the lines and pulses the address latch enable. T2 turns the shared lines around and asserts the strobe. T3 samples READY. T4 releases the strobe. While READY is low, wait clocks (Tw) are added between T3 and T4. Between cycles an external master may request the bus with a hold input. The block grants it with a hold acknowledge and floats every bus output until the request is withdrawn. Output enables stand in for the tri-state pads, which sit outside the block.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1, `ale_o` is high, `ad_o` carries address bits 15..0 with `ad_oe_o` high, and `as_o` carries address bits 19..16. `ale_o` is never high for two clocks in a row.
- R2: From T2 through T4, `as_o` carries the status code: bit 3 is 0, bit 2 is the latched interrupt-enable flag, and bits 1..0 are the segment class (00 extra, 01 stack, 10 code, 11 data).
- R3: On a read, `ad_oe_o` is low from T2 on, and `rd_n_o` is low in T2, T3 and every Tw. `ad_i` is captured at the clock edge that ends T3 or the last Tw. In T4 it appears on `rdata_o` with `rdata_valid_o` high and `rd_n_o` high. `rd_n_o` and `wr_n_o` are never low together.
- R4: On a write, `ad_o` carries the write data with `ad_oe_o` high from T2 through T4. `wr_n_o` is low in T2, T3 and every Tw, and high in T4.
- R5: While `ready_i` is low at the end of T3 or of a Tw, a further Tw follows and the active strobe stays low. The cycle moves to T4 at the first edge where `ready_i` is high.
- R6: During a cycle, `dtr_o` is 1 for a write and 0 for a read. `den_n_o` is low in T2, T3 and Tw, and also in T4 for writes.
- R7: During a cycle, `mio_o` is 1 for an I/O access and 0 for a memory access.
- R8: During a cycle, `bhe_n_o` is 0 when the upper byte lane takes part: a word transfer, or a byte transfer at an odd address. It is 1 for a byte transfer at an even address.
- R9: `hold_i` is honoured only in idle or at the end of T4. A cycle already under way runs to completion. While `hlda_o` is high, `ad_oe_o`, `as_oe_o` and `ctl_oe_o` are all low.
- R10: `hlda_o` falls at the first clock edge that samples `hold_i` low. While in hold, `req_ready_o` is 0 and no cycle starts.
- R11: A request pending in T4 starts its T1 in the very next clock, with no idle clock in between.
- R12: After reset, the block is idle: `ale_o` 0, `rd_n_o` 1, `wr_n_o` 1, `ad_oe_o` 0, `hlda_o` 0 and `req_ready_o` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request present |
| req_ready_o | output | 1 | Request accepted this clock |
| req_write_i | input | 1 | 1 write, 0 read |
| req_io_i | input | 1 | 1 I/O space, 0 memory |
| req_word_i | input | 1 | 1 word transfer, 0 byte |
| req_addr_i | input | 20 | Physical address |
| req_wdata_i | input | 16 | Write data |
| req_seg_i | input | 2 | Segment class code |
| intr_en_i | input | 1 | Interrupt-enable flag shown in status |
| rdata_o | output | 16 | Captured read data |
| rdata_valid_o | output | 1 | Read data valid (T4 of a read) |
| done_o | output | 1 | High in T4 |
| ad_o | output | 16 | Shared address/data lines, outgoing |
| ad_oe_o | output | 1 | Drive enable for shared lines |
| ad_i | input | 16 | Shared lines, incoming |
| as_o | output | 4 | Upper address / status lines |
| as_oe_o | output | 1 | Drive enable for upper lines |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| mio_o | output | 1 | 1 I/O, 0 memory |
| dtr_o | output | 1 | Transceiver direction, 1 transmit |
| den_n_o | output | 1 | Transceiver enable, active low |
| bhe_n_o | output | 1 | Upper byte lane enable, active low |
| ctl_oe_o | output | 1 | Drive enable for the control strobes |
| ready_i | input | 1 | Target ready; low inserts wait clocks |
| hold_i | input | 1 | External bus request |
| hlda_o | output | 1 | Bus granted to external master |

## Verification
The bench builds the block with its defaults: a 20-bit address over 16 shared lines, which leaves four upper lines. That width makes the full status layout visible, including the always-low top bit, the interrupt-enable bit and both segment bits. The 16 shared lines carry both byte lanes, so all three upper-lane enable cases can be reached. The bench drives reads and writes with zero, one and three wait clocks, and a back-to-back pair handed over at T4. It also raises hold both in idle and in the middle of a cycle, which shows that the grant waits for the end of the cycle.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_HOLD
  } bus_st_e;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;
endpackage

// File: rtl/mux_bus_fsm.sv
module mux_bus_fsm
  import mux_bus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    hold_i,
  input  logic    ready_i,
  output bus_st_e st_o,
  output logic    req_ready_o,
  output logic    accept_o
);
  bus_st_e st_q, st_d;
  logic    boundary;

  // cycle boundary: the only points where hold or a new request is taken
  assign boundary    = (st_q == ST_IDLE) || (st_q == ST_T4);
  assign req_ready_o = boundary && !hold_i;
  assign accept_o    = req_ready_o && req_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_T4: begin
        if (hold_i)           st_d = ST_HOLD;
        else if (req_valid_i) st_d = ST_T1;
        else                  st_d = ST_IDLE;
      end
      ST_T1:         st_d = ST_T2;
      ST_T2:         st_d = ST_T3;
      ST_T3, ST_TW:  st_d = ready_i ? ST_T4 : ST_TW;
      ST_HOLD:       st_d = hold_i ? ST_HOLD : ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/mux_bus_req_reg.sv
module mux_bus_req_reg #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_seg_i,
  input  logic              intr_en_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              q_write_o,
  output logic              q_io_o,
  output logic              q_bhe_n_o,
  output logic [ADDR_W-1:0] q_addr_o,
  output logic [DATA_W-1:0] q_wdata_o,
  output logic [1:0]        q_seg_o,
  output logic              q_ie_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_write_o <= 1'b0;
      q_io_o    <= 1'b0;
      q_bhe_n_o <= 1'b1;
      q_addr_o  <= '0;
      q_wdata_o <= '0;
      q_seg_o   <= '0;
      q_ie_o    <= 1'b0;
    end else if (accept_i) begin
      q_write_o <= req_write_i;
      q_io_o    <= req_io_i;
      // upper lane used by words and by odd-address bytes
      q_bhe_n_o <= !(req_word_i || req_addr_i[0]);
      q_addr_o  <= req_addr_i;
      q_wdata_o <= req_wdata_i;
      q_seg_o   <= req_seg_i;
      q_ie_o    <= intr_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= ad_i;
    end
  end
endmodule

// File: rtl/mux_bus_pads.sv
module mux_bus_pads
  import mux_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned STAT_W = ADDR_W - DATA_W
) (
  input  bus_st_e           st_i,
  input  logic              q_write_i,
  input  logic              q_io_i,
  input  logic              q_bhe_n_i,
  input  logic [ADDR_W-1:0] q_addr_i,
  input  logic [DATA_W-1:0] q_wdata_i,
  input  logic [1:0]        q_seg_i,
  input  logic              q_ie_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [STAT_W-1:0] as_o,
  output logic              as_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              mio_o,
  output logic              dtr_o,
  output logic              den_n_o,
  output logic              bhe_n_o,
  output logic              ctl_oe_o
);
  logic              in_cyc, strobe_ph, data_ph, addr_ph;
  logic [STAT_W-1:0] status;

  assign addr_ph   = (st_i == ST_T1);
  assign strobe_ph = (st_i == ST_T2) || (st_i == ST_T3) || (st_i == ST_TW);
  assign data_ph   = strobe_ph || (st_i == ST_T4);
  assign in_cyc    = addr_ph || data_ph;

  generate
    if (STAT_W > 3) begin : g_stat_pad
      assign status = {{(STAT_W-3){1'b0}}, q_ie_i, q_seg_i};
    end else begin : g_stat_min
      assign status = {q_ie_i, q_seg_i};
    end
  endgenerate

  assign ad_o     = addr_ph ? q_addr_i[DATA_W-1:0] : q_wdata_i;
  assign ad_oe_o  = addr_ph || (data_ph && q_write_i);
  assign as_o     = addr_ph ? q_addr_i[ADDR_W-1:DATA_W] : status;
  assign as_oe_o  = in_cyc;
  assign ale_o    = addr_ph;
  assign rd_n_o   = !(strobe_ph && !q_write_i);
  assign wr_n_o   = !(strobe_ph && q_write_i);
  assign mio_o    = in_cyc && q_io_i;
  assign dtr_o    = in_cyc ? q_write_i : 1'b1;
  assign den_n_o  = !(strobe_ph || ((st_i == ST_T4) && q_write_i));
  assign bhe_n_o  = in_cyc ? q_bhe_n_i : 1'b1;
  assign ctl_oe_o = (st_i != ST_HOLD);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned STAT_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_seg_i,
  input  logic              intr_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              done_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [STAT_W-1:0] as_o,
  output logic              as_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              mio_o,
  output logic              dtr_o,
  output logic              den_n_o,
  output logic              bhe_n_o,
  output logic              ctl_oe_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o
);
  bus_st_e           st;
  logic              accept, capture;
  logic              q_write, q_io, q_bhe_n, q_ie;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [1:0]        q_seg;

  mux_bus_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .hold_i      (hold_i),
    .ready_i     (ready_i),
    .st_o        (st),
    .req_ready_o (req_ready_o),
    .accept_o    (accept)
  );

  assign capture = ((st == ST_T3) || (st == ST_TW)) && ready_i && !q_write;

  mux_bus_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .req_write_i (req_write_i),
    .req_io_i    (req_io_i),
    .req_word_i  (req_word_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_seg_i   (req_seg_i),
    .intr_en_i   (intr_en_i),
    .capture_i   (capture),
    .ad_i        (ad_i),
    .q_write_o   (q_write),
    .q_io_o      (q_io),
    .q_bhe_n_o   (q_bhe_n),
    .q_addr_o    (q_addr),
    .q_wdata_o   (q_wdata),
    .q_seg_o     (q_seg),
    .q_ie_o      (q_ie),
    .rdata_o     (rdata_o),
    .rvalid_o    (rdata_valid_o)
  );

  mux_bus_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
    .st_i      (st),
    .q_write_i (q_write),
    .q_io_i    (q_io),
    .q_bhe_n_i (q_bhe_n),
    .q_addr_i  (q_addr),
    .q_wdata_i (q_wdata),
    .q_seg_i   (q_seg),
    .q_ie_i    (q_ie),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .as_o      (as_o),
    .as_oe_o   (as_oe_o),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .mio_o     (mio_o),
    .dtr_o     (dtr_o),
    .den_n_o   (den_n_o),
    .bhe_n_o   (bhe_n_o),
    .ctl_oe_o  (ctl_oe_o)
  );

  assign done_o = (st == ST_T4);
  assign hlda_o = (st == ST_HOLD);
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int unsigned STAT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_o,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic              ready_i,
  input logic              hold_i,
  input logic              hlda_o,
  input logic              ad_oe_o,
  input logic              as_oe_o,
  input logic              ctl_oe_o,
  input logic [STAT_W-1:0] as_o
);
  a_r1_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  a_r2_top_status_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_oe_o && !ale_o) |-> !as_o[STAT_W-1]);

  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_n_o || wr_n_o));

  a_r5_wait_keeps_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o && !ready_i) |=> !rd_n_o);

  a_r5_wait_keeps_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_o && !ready_i) |=> !wr_n_o);

  a_r9_hold_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !as_oe_o && !ctl_oe_o));

  a_r9_grant_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(hold_i));

  a_r10_hlda_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && !hold_i) |=> !hlda_o);
endmodule

bind mux_bus_seq mux_bus_seq_chk #(.STAT_W(ADDR_W - DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ale_o    (ale_o),
  .rd_n_o   (rd_n_o),
  .wr_n_o   (wr_n_o),
  .ready_i  (ready_i),
  .hold_i   (hold_i),
  .hlda_o   (hlda_o),
  .ad_oe_o  (ad_oe_o),
  .as_oe_o  (as_oe_o),
  .ctl_oe_o (ctl_oe_o),
  .as_o     (as_o)
);

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic        req_write = 1'b0, req_io = 1'b0, req_word = 1'b1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_seg = '0;
  logic        intr_en = 1'b0;
  logic [15:0] rdata;
  logic        rdata_valid, done;
  logic [15:0] ad_o, ad_i = '0;
  logic        ad_oe;
  logic [3:0]  as_o;
  logic        as_oe, ale, rd_n, wr_n, mio, dtr, den_n, bhe_n, ctl_oe;
  logic        ready = 1'b1, hold = 1'b0, hlda;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_io_i(req_io), .req_word_i(req_word),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_seg_i(req_seg),
    .intr_en_i(intr_en),
    .rdata_o(rdata), .rdata_valid_o(rdata_valid), .done_o(done),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i),
    .as_o(as_o), .as_oe_o(as_oe), .ale_o(ale),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .mio_o(mio), .dtr_o(dtr),
    .den_n_o(den_n), .bhe_n_o(bhe_n), .ctl_oe_o(ctl_oe),
    .ready_i(ready), .hold_i(hold), .hlda_o(hlda)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic present(input logic wr, input logic io, input logic word,
                         input logic [19:0] addr, input logic [15:0] wd,
                         input logic [1:0] seg, input logic ie);
    req_write = wr; req_io = io; req_word = word; req_addr = addr;
    req_wdata = wd; req_seg = seg; intr_en = ie; req_valid = 1'b1;
  endtask

  // one full cycle; entered at a negedge in idle, leaves at the T4 negedge
  task automatic run_cycle(input logic wr, input logic io, input logic word,
                           input logic [19:0] addr, input logic [15:0] wd,
                           input logic [1:0] seg, input logic ie,
                           input int waits, input logic [15:0] rd_val);
    logic strobe_n;
    logic exp_bhe_n;
    exp_bhe_n = !(word || addr[0]);
    @(negedge clk);
    present(wr, io, word, addr, wd, seg, ie);
    @(negedge clk);                                  // T1
    req_valid = 1'b0;
    check("R1 ale in T1", ale, 1);
    check("R1 ad carries low address", ad_o, addr[15:0]);
    check("R1 ad driven in T1", ad_oe, 1);
    check("R1 as carries high address", as_o, addr[19:16]);
    check("R7 mio", mio, io);
    check("R8 bhe_n", bhe_n, exp_bhe_n);
    ready = (waits == 0);
    ad_i  = rd_val;
    @(negedge clk);                                  // T2
    strobe_n = wr ? wr_n : rd_n;
    check("R1 ale dropped", ale, 0);
    check("R2 status code", as_o, {1'b0, ie, seg});
    check(wr ? "R4 wr strobe in T2" : "R3 rd strobe in T2", strobe_n, 0);
    check(wr ? "R4 ad driven" : "R3 ad released", ad_oe, wr);
    if (wr) check("R4 write data on ad", ad_o, wd);
    check("R6 dtr", dtr, wr);
    check("R6 den in T2", den_n, 0);
    @(negedge clk);                                  // T3
    strobe_n = wr ? wr_n : rd_n;
    check(wr ? "R4 wr strobe in T3" : "R3 rd strobe in T3", strobe_n, 0);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);                                // Tw
      strobe_n = wr ? wr_n : rd_n;
      check("R5 strobe held in wait", strobe_n, 0);
      check("R5 not done in wait", done, 0);
      if (w == waits - 1) ready = 1'b1;
    end
    @(negedge clk);                                  // T4
    check("R5 done in T4", done, 1);
    check(wr ? "R4 wr released in T4" : "R3 rd released in T4", wr ? wr_n : rd_n, 1);
    check("R3 strobes not both low", {rd_n, wr_n} != 2'b00, 1);
    check("R6 den in T4", den_n, !wr);
    if (wr) begin
      check("R4 ad still driven in T4", ad_oe, 1);
    end else begin
      check("R3 rdata_valid", rdata_valid, 1);
      check("R3 read data", rdata, rd_val);
    end
  endtask

  task automatic t_reset;
    check("R12 ale", ale, 0);
    check("R12 rd_n", rd_n, 1);
    check("R12 wr_n", wr_n, 1);
    check("R12 ad_oe", ad_oe, 0);
    check("R12 hlda", hlda, 0);
    check("R12 req_ready", req_ready, 1);
  endtask

  task automatic t_back_to_back;
    run_cycle(1, 0, 1, 20'h12340, 16'hbeef, 2'b11, 0, 0, 16'h0);
    present(0, 1, 0, 20'h00071, 16'h0, 2'b01, 1);    // pending in T4
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 T1 right after T4", ale, 1);
    check("R11 new address", ad_o, 16'h0071);
    check("R7 io in second cycle", mio, 1);
    ready = 1'b1;
    ad_i  = 16'h5a5a;
    repeat (3) @(negedge clk);
    check("R11 second read data", rdata, 16'h5a5a);
  endtask

  task automatic t_hold_idle;
    @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    check("R9 hlda granted", hlda, 1);
    check("R9 ad floats", ad_oe, 0);
    check("R9 as floats", as_oe, 0);
    check("R9 strobes float", ctl_oe, 0);
    check("R10 no accept in hold", req_ready, 0);
    present(0, 0, 1, 20'h11111, 16'h0, 2'b00, 0);
    @(negedge clk);
    check("R10 no cycle starts in hold", ale, 0);
    check("R10 hlda kept", hlda, 1);
    hold = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 hlda dropped one clock later", hlda, 0);
    check("R10 ready again", req_ready, 1);
  endtask

  task automatic t_hold_mid;
    @(negedge clk);
    present(0, 0, 1, 20'h22222, 16'h0, 2'b10, 0);
    ready = 1'b1;
    @(negedge clk);                                  // T1
    req_valid = 1'b0;
    hold = 1'b1;
    @(negedge clk);                                  // T2
    check("R9 no grant mid cycle", hlda, 0);
    check("R9 cycle continues", rd_n, 0);
    @(negedge clk);                                  // T3
    @(negedge clk);                                  // T4
    check("R9 no grant in T4", hlda, 0);
    check("R9 cycle completes", done, 1);
    @(negedge clk);
    check("R9 grant after cycle", hlda, 1);
    hold = 1'b0;
    @(negedge clk);
    check("R10 hlda released", hlda, 0);
  endtask

  initial begin : watchdog
    #(8 * 20000);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cycle(0, 0, 1, 20'hA1234, 16'h0,    2'b00, 1, 0, 16'hc3a5);  // read, no waits
    run_cycle(1, 1, 0, 20'h00301, 16'h00ff, 2'b01, 0, 0, 16'h0);     // byte write, odd
    run_cycle(0, 0, 0, 20'h5fffe, 16'h0,    2'b10, 0, 1, 16'h1234);  // byte read, even, 1 wait
    run_cycle(1, 0, 1, 20'hfedcb, 16'h6789, 2'b11, 1, 3, 16'h0);     // word write, 3 waits
    t_back_to_back();
    t_hold_idle();
    t_hold_mid();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule